// File: doc/BRIEF.md
# Multiply-Divide Issue Rate Limiter

This block sits in front of a shared, multi-cycle multiply/divide unit and decides on each cycle whether a request may start there. It does not use a fixed initiation interval. Each time it accepts a new operation it records the cycle number and the kind of operation. For a divide it also records the operand-size class. The next newcomer must then wait a number of cycles that depends on that record. A multiply imposes one spacing. Each of the four divide size classes imposes its own spacing. Any other operation imposes none.

The pipeline supplies a free-running 32-bit cycle count. It also says whether the requester already holds a slot in the unit with the same command, and whether a slot is free. A resident requester is re-granted at once and the record is left untouched. The answer is combinational, so the stage can act on it in the same cycle. The record changes on the clock edge at which a fresh request is granted.

Top module: `mdu_issue_gate`

## Requirements
- R1: With `req_valid` low, both `grant` and `deny` are low in that cycle, whatever the other inputs are.
- R2: After a granted multiply (`req_op` = 2'b01) at cycle L, a fresh request with a free slot at cycle N is granted exactly when L + MUL_RATE <= N. Otherwise it is denied.
- R3: After a granted divide (`req_op` = 2'b10) at cycle L, the spacing is chosen by the size class that came with that divide: `req_div_size` 2'b00 = 8 bits uses DIV8_RATE, 2'b01 = 16 bits uses DIV16_RATE, 2'b10 = 24 bits uses DIV24_RATE, 2'b11 = 32 bits uses DIV32_RATE. A fresh request is granted exactly when L + spacing <= N.
- R4: After a granted operation of any other class (`req_op` 2'b00 or 2'b11), the spacing is 0.
- R5: After reset the record holds no operation and cycle 0, so a fresh request with a free slot is granted at any cycle, including cycle 0.
- R6: The recorded cycle, class and size change only on a clock edge where a fresh (non-resident) request is granted. A denied request leaves them as they were.
- R7: A valid request with `req_resident` high is granted regardless of spacing and slot availability, and it does not change the record.
- R8: The sum L + spacing is formed one bit wider than the cycle count. A window that extends past the 32-bit wrap therefore keeps the request denied; it is never taken as already over.
- R9: For a valid request, exactly one of `grant` and `deny` is high.
- R10: A fresh request with `slot_avail` low is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | Operation class: 01 multiply, 10 divide, 00/11 other |
| req_div_size | input | 2 | Divide size class: 00=8, 01=16, 10=24, 11=32 bits |
| req_resident | input | 1 | Requester already holds a slot with the same command |
| slot_avail | input | 1 | The unit has a free slot for a fresh request |
| cycle_now | input | CW | Current cycle count |
| grant | output | 1 | Request accepted this cycle |
| deny | output | 1 | Request refused this cycle |

## Verification
`grant` and `deny` follow the present inputs and the stored record with no register in between. The bench drives each vector after a falling edge and samples the outputs 1 ns later, in the same cycle. The record is written on the next rising edge and can only be seen through the verdict on the following vector, so the bench's model updates its own record after that edge. Spacing boundaries are swept one cycle at a time around every previous-operation kind, including a window that runs across the 32-bit wrap of the cycle count.

// File: rtl/mdu_gate_pkg.sv
package mdu_gate_pkg;

  // kind of the most recently accepted operation
  typedef enum logic [1:0] {
    HIST_NONE  = 2'b00,
    HIST_MUL   = 2'b01,
    HIST_DIV   = 2'b10,
    HIST_OTHER = 2'b11
  } hist_kind_t;

  // request operation encodings
  localparam logic [1:0] OPC_MUL = 2'b01;
  localparam logic [1:0] OPC_DIV = 2'b10;

  // divide size classes
  localparam int N_DIV_CLASSES = 4;

  function automatic hist_kind_t classify_op(input logic [1:0] op);
    case (op)
      OPC_MUL: classify_op = HIST_MUL;
      OPC_DIV: classify_op = HIST_DIV;
      default: classify_op = HIST_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/mdu_gate_history.sv
module mdu_gate_history
  import mdu_gate_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  hist_kind_t    kind_in,
  input  logic [1:0]    size_in,
  input  logic [CW-1:0] cycle_in,
  output hist_kind_t    hist_kind,
  output logic [1:0]    hist_size,
  output logic [CW-1:0] hist_cycle
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_kind  <= HIST_NONE;
      hist_size  <= 2'b00;
      hist_cycle <= '0;
    end else if (accept) begin
      hist_kind  <= kind_in;
      hist_cycle <= cycle_in;
      if (kind_in == HIST_DIV) begin
        hist_size <= size_in;
      end
    end
  end

endmodule

// File: rtl/mdu_gate_spacing.sv
module mdu_gate_spacing
  import mdu_gate_pkg::*;
#(
  parameter int RW          = 8,
  parameter int MUL_RATE    = 4,
  parameter int DIV8_RATE   = 2,
  parameter int DIV16_RATE  = 5,
  parameter int DIV24_RATE  = 7,
  parameter int DIV32_RATE  = 11
) (
  input  hist_kind_t    hist_kind,
  input  logic [1:0]    hist_size,
  output logic [RW-1:0] spacing
);

  localparam logic [RW-1:0] MUL_GAP = RW'(MUL_RATE);
  localparam int DIV_RATES [N_DIV_CLASSES] =
    '{DIV8_RATE, DIV16_RATE, DIV24_RATE, DIV32_RATE};

  logic [RW-1:0] div_gap [N_DIV_CLASSES];

  genvar gi;
  generate
    for (gi = 0; gi < N_DIV_CLASSES; gi++) begin : g_div_gap
      assign div_gap[gi] = RW'(DIV_RATES[gi]);
    end
  endgenerate

  function automatic logic [RW-1:0] pick_gap(
    input hist_kind_t    kind,
    input logic [1:0]    size,
    input logic [RW-1:0] mul_g,
    input logic [RW-1:0] d0,
    input logic [RW-1:0] d1,
    input logic [RW-1:0] d2,
    input logic [RW-1:0] d3
  );
    logic [RW-1:0] dsel;
    case (size)
      2'b00:   dsel = d0;
      2'b01:   dsel = d1;
      2'b10:   dsel = d2;
      default: dsel = d3;
    endcase
    case (kind)
      HIST_MUL: pick_gap = mul_g;
      HIST_DIV: pick_gap = dsel;
      default:  pick_gap = '0;
    endcase
  endfunction

  assign spacing = pick_gap(hist_kind, hist_size, MUL_GAP,
                            div_gap[0], div_gap[1], div_gap[2], div_gap[3]);

endmodule

// File: rtl/mdu_gate_ready.sv
module mdu_gate_ready #(
  parameter int CW = 32,
  parameter int RW = 8
) (
  input  logic [CW-1:0] hist_cycle,
  input  logic [RW-1:0] spacing,
  input  logic [CW-1:0] cycle_now,
  output logic [CW:0]   window_end,
  output logic          ready
);

  // sum carried one bit wider than the cycle count
  function automatic logic [CW:0] wide_sum(input logic [CW-1:0] base,
                                           input logic [RW-1:0] gap);
    wide_sum = {1'b0, base} + (CW+1)'(gap);
  endfunction

  function automatic logic still_waiting(input logic [CW:0]   wend,
                                         input logic [CW-1:0] now);
    still_waiting = wend > {1'b0, now};
  endfunction

  assign window_end = wide_sum(hist_cycle, spacing);
  assign ready      = !still_waiting(window_end, cycle_now);

endmodule

// File: rtl/mdu_issue_gate.sv
module mdu_issue_gate
  import mdu_gate_pkg::*;
#(
  parameter int CW         = 32,
  parameter int RW         = 8,
  parameter int MUL_RATE   = 4,
  parameter int DIV8_RATE  = 2,
  parameter int DIV16_RATE = 5,
  parameter int DIV24_RATE = 7,
  parameter int DIV32_RATE = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [1:0]    req_div_size,
  input  logic          req_resident,
  input  logic          slot_avail,
  input  logic [CW-1:0] cycle_now,
  output logic          grant,
  output logic          deny
);

  hist_kind_t    hist_kind;
  logic [1:0]    hist_size;
  logic [CW-1:0] hist_cycle;
  logic [RW-1:0] spacing;
  logic [CW:0]   window_end;
  logic          ready;
  logic          fresh_req;
  logic          accept_evt;
  logic          regrant_evt;
  hist_kind_t    req_kind;

  assign req_kind    = classify_op(req_op);
  assign fresh_req   = req_valid && !req_resident;
  assign regrant_evt = req_valid && req_resident;
  assign accept_evt  = fresh_req && slot_avail && ready;
  assign grant       = regrant_evt || accept_evt;
  assign deny        = req_valid && !grant;

  mdu_gate_history #(.CW(CW)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_evt),
    .kind_in   (req_kind),
    .size_in   (req_div_size),
    .cycle_in  (cycle_now),
    .hist_kind (hist_kind),
    .hist_size (hist_size),
    .hist_cycle(hist_cycle)
  );

  mdu_gate_spacing #(
    .RW(RW), .MUL_RATE(MUL_RATE), .DIV8_RATE(DIV8_RATE),
    .DIV16_RATE(DIV16_RATE), .DIV24_RATE(DIV24_RATE), .DIV32_RATE(DIV32_RATE)
  ) u_space (
    .hist_kind(hist_kind),
    .hist_size(hist_size),
    .spacing  (spacing)
  );

  mdu_gate_ready #(.CW(CW), .RW(RW)) u_ready (
    .hist_cycle(hist_cycle),
    .spacing   (spacing),
    .cycle_now (cycle_now),
    .window_end(window_end),
    .ready     (ready)
  );

endmodule

// File: rtl/mdu_issue_gate_chk.sv
module mdu_issue_gate_chk
  import mdu_gate_pkg::*;
#(
  parameter int CW       = 32,
  parameter int MUL_RATE = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_resident,
  input logic          slot_avail,
  input logic [CW-1:0] cycle_now,
  input logic          grant,
  input logic          deny,
  input logic          accept_evt,
  input hist_kind_t    hist_kind,
  input logic [CW-1:0] hist_cycle,
  input logic [CW:0]   window_end
);

  // R1
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !deny));

  // R9
  a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (grant != deny));

  // R7
  a_r7_resident_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_resident) |-> grant);

  // R10
  a_r10_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_resident && !slot_avail) |-> !grant);

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_evt |=> ($stable(hist_cycle) && $stable(hist_kind)));

  a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (hist_cycle == $past(cycle_now)));

  // R8
  a_r8_window_done: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (window_end <= {1'b0, cycle_now}));

  // R2
  a_r2_mul_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && hist_kind == HIST_MUL) |->
      (({1'b0, cycle_now} - {1'b0, hist_cycle}) >= (CW+1)'(MUL_RATE)));

  // R4
  a_r4_other_free: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_resident && slot_avail &&
     (hist_kind == HIST_OTHER || hist_kind == HIST_NONE) &&
     cycle_now >= hist_cycle) |-> grant);

endmodule

bind mdu_issue_gate mdu_issue_gate_chk #(.CW(CW), .MUL_RATE(MUL_RATE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_resident(req_resident),
  .slot_avail  (slot_avail),
  .cycle_now   (cycle_now),
  .grant       (grant),
  .deny        (deny),
  .accept_evt  (accept_evt),
  .hist_kind   (hist_kind),
  .hist_cycle  (hist_cycle),
  .window_end  (window_end)
);

// File: tb/mdu_issue_gate_tb.sv
module mdu_issue_gate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T_MUL = 4;
  localparam int T_D8  = 2;
  localparam int T_D16 = 5;
  localparam int T_D24 = 7;
  localparam int T_D32 = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [1:0]  req_div_size = 2'b00;
  logic        req_resident = 1'b0;
  logic        slot_avail = 1'b0;
  logic [31:0] cycle_now = '0;
  logic        grant;
  logic        deny;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  // bench record: kind 0 none, 1 mul, 2 div, 3 other
  longint m_last = 0;
  int     m_kind = 0;
  int     m_size = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdu_issue_gate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_div_size(req_div_size), .req_resident(req_resident),
    .slot_avail(slot_avail), .cycle_now(cycle_now),
    .grant(grant), .deny(deny)
  );

  function automatic int gap_of(input int kind, input int size);
    if (kind == 1) return T_MUL;
    if (kind == 2) begin
      case (size)
        0: return T_D8;
        1: return T_D16;
        2: return T_D24;
        default: return T_D32;
      endcase
    end
    return 0;
  endfunction

  function automatic int kind_of(input logic [1:0] op);
    if (op == 2'b01) return 1;
    if (op == 2'b10) return 2;
    return 3;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_last = 0; m_kind = 0; m_size = 0;
  endtask

  // drive after a falling edge, sample 1 ns later, update model after the rise
  task automatic apply(input bit v, input logic [1:0] op, input logic [1:0] sz,
                       input bit res, input bit slot, input logic [31:0] now,
                       input string rq);
    bit exp_g, exp_d, fresh_ok;
    @(negedge clk);
    req_valid = v; req_op = op; req_div_size = sz;
    req_resident = res; slot_avail = slot; cycle_now = now;
    #1;
    fresh_ok = v && !res && slot &&
               ((m_last + longint'(gap_of(m_kind, m_size))) <= longint'(now));
    exp_g = (v && res) || fresh_ok;
    exp_d = v && !exp_g;
    n_vec++;
    if (grant !== exp_g || deny !== exp_d) begin
      n_bad++;
      $display("FAIL %s: now=%0d op=%0b res=%0b slot=%0b grant/deny=%b%b expected %b%b",
               rq, now, op, res, slot, grant, deny, exp_g, exp_d);
    end
    @(posedge clk);
    if (fresh_ok) begin
      m_last = longint'(now);
      m_kind = kind_of(op);
      if (m_kind == 2) m_size = int'(sz);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] base;
    logic [31:0] seed;
    do_reset();

    // R5: fresh request at cycle 0 right after reset
    apply(1, 2'b01, 2'b00, 0, 1, 32'd0, "R5");
    do_reset();
    apply(1, 2'b10, 2'b11, 0, 1, 32'd0, "R5");

    // R1: idle cycles with varied other inputs
    for (int i = 0; i < 8; i++)
      apply(0, 2'(i), 2'(i >> 1), i[0], i[1], 32'(i * 3), "R1");

    base = 32'd1000;
    // R2/R3/R4: sweep probe distance for every previous-operation kind
    for (int pk = 0; pk < 6; pk++) begin
      for (int d = 0; d <= 13; d++) begin
        logic [1:0] pop, psz;
        string rq;
        case (pk)
          0: begin pop = 2'b01; psz = 2'b00; rq = "R2"; end
          1: begin pop = 2'b10; psz = 2'b00; rq = "R3"; end
          2: begin pop = 2'b10; psz = 2'b01; rq = "R3"; end
          3: begin pop = 2'b10; psz = 2'b10; rq = "R3"; end
          4: begin pop = 2'b10; psz = 2'b11; rq = "R3"; end
          default: begin pop = 2'(d % 2 == 0 ? 0 : 3); psz = 2'b11; rq = "R4"; end
        endcase
        apply(1, pop, psz, 0, 1, base, rq);
        apply(1, 2'(d % 4), 2'b00, 0, 1, base + 32'(d), rq);
        base = base + 32'd100;
      end
    end

    // R7: resident regrant inside a window, then record must be unchanged
    apply(1, 2'b10, 2'b11, 0, 1, base, "R7");
    apply(1, 2'b01, 2'b00, 1, 0, base + 1, "R7");
    apply(1, 2'b01, 2'b00, 0, 1, base + 10, "R7");
    apply(1, 2'b01, 2'b00, 0, 1, base + 11, "R7");
    base = base + 32'd100;

    // R10 and R6: no slot -> deny, record kept; denied in window -> kept
    apply(1, 2'b01, 2'b00, 0, 1, base, "R6");
    apply(1, 2'b00, 2'b00, 0, 0, base + 20, "R10");
    apply(1, 2'b00, 2'b00, 0, 1, base + 2, "R6");
    apply(1, 2'b00, 2'b00, 0, 1, base + 3, "R6");
    apply(1, 2'b00, 2'b00, 0, 1, base + 4, "R6");
    base = base + 32'd100;

    // mixed stress with small steps, R9 verdict consistency
    seed = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      base = base + 32'(seed[27:26]);
      apply(seed[31] | seed[30], seed[25:24], seed[23:22],
            seed[21] & seed[20], seed[19] | seed[18], base, "R9");
    end

    // R8: window crossing the 32-bit wrap must keep denying
    do_reset();
    apply(1, 2'b10, 2'b11, 0, 1, 32'hFFFF_FFF8, "R8");
    apply(1, 2'b01, 2'b00, 0, 1, 32'hFFFF_FFFF, "R8");
    apply(1, 2'b01, 2'b00, 0, 1, 32'hFFFF_FFFE, "R8");
    apply(1, 2'b01, 2'b00, 0, 1, 32'd2, "R8");
    apply(1, 2'b01, 2'b00, 0, 1, 32'hFFFF_FFF8 + 32'd11 - 32'd1 + 32'd0, "R8");

    @(negedge clk);
    req_valid = 1'b0;
    finish_run();
  end

endmodule